// File: doc/BRIEF.md
# Haar Feature Evaluation Datapath

This block scores one weighted-rectangle feature of a cascade object detector. Each cycle it can accept one feature: twelve integral-image values (four corners for each of up to three rectangles), a 2-bit weight code per rectangle, a signed threshold and two leaf values. From the corners it forms each rectangle's pixel sum, scales each sum by its weight and adds the three products into a signed feature value. It then selects one of the two leaf values by comparing that feature value against the threshold.

The datapath is a two-register pipeline. The first register holds the rectangle sums next to the feature's parameters. The second register holds the chosen leaf. A valid bit moves through both registers with the data. The block accepts a new feature on every cycle and has no stall. Fetching corners from the window buffer, holding the feature table and adding leaf values into a stage total all belong to the surrounding logic. There is no control state machine: the only sequencing is the valid bit moving from one register to the next.

Top module: `hf_feature_eval`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `out_leaf` is 0.
- R2: Rectangle k takes its corners from `in_corners` at bits `[(4k+c)*17 +: 17]`, with c = 0 top-left, 1 top-right, 2 bottom-left and 3 bottom-right. Its sum is bottom-right − top-right − bottom-left + top-left, taken as a signed value.
- R3: The weight code of rectangle k is `in_weights[2k+1:2k]`. Code 00 means weight 0, 01 means −1, 10 means ×2 and 11 means ×3.
- R4: The feature value is the exact sum of the three weighted rectangle sums. It does not overflow for any corner values, including full-scale sums of either sign under ×3 weights.
- R5: The threshold is a signed 23-bit value. The result is `in_leaf_right` only when the feature value is strictly greater than the threshold. Otherwise it is `in_leaf_left`, and this includes the case where the two are equal.
- R6: A feature accepted with `in_valid` high at a rising edge shows on `out_leaf` with `out_valid` high after the second rising edge. Each accepted feature gives exactly one valid cycle, and features on back-to-back cycles give back-to-back results.
- R7: When `out_valid` is low, `out_leaf` holds the last result it showed (or 0 after reset).
- R8: The corner values of a rectangle with weight code 00 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A feature is presented this cycle |
| in_corners | input | 204 | Twelve 17-bit integral-image corners |
| in_weights | input | 6 | Three 2-bit weight codes |
| in_threshold | input | 23 | Signed feature threshold |
| in_leaf_left | input | 16 | Result when feature value ≤ threshold |
| in_leaf_right | input | 16 | Result when feature value > threshold |
| out_valid | output | 1 | Result valid |
| out_leaf | output | 16 | Selected leaf value |

## Verification
The bench places the threshold at the feature value, one above it and one below it. A comparison that is not strict, or that is unsigned, would pick the wrong leaf at equality or for negative totals. Full-scale corners under ×3 weights, with both positive and negative totals, show up any sum that is too narrow, because the sign wraps and the chosen side flips. It also sends gaps and back-to-back features. A latency that is off by one, or a leaf register that follows its input while no result is valid, would show as a misaligned or drifting output. Random corners on a zero-weight rectangle show up a decode that leaks that rectangle into the total.

// File: rtl/hf_pkg.sv
package hf_pkg;

    typedef enum logic [1:0] {
        W_ZERO   = 2'b00,
        W_NEG    = 2'b01,
        W_DOUBLE = 2'b10,
        W_TRIPLE = 2'b11
    } weight_e;

    localparam int CORNERS_PER_RECT = 4;
    localparam int C_TL = 0;
    localparam int C_TR = 1;
    localparam int C_BL = 2;
    localparam int C_BR = 3;

endpackage

// File: rtl/hf_rect_stage.sv
module hf_rect_stage #(
    parameter int CORNER_W = 17,
    parameter int NUM_RECT = 3,
    parameter int LEAF_W   = 16,
    parameter int FEAT_W   = 23,
    localparam int RECT_W  = CORNER_W + 2,
    localparam int IN_W    = NUM_RECT * hf_pkg::CORNERS_PER_RECT * CORNER_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [IN_W-1:0]            in_corners,
    input  logic [2*NUM_RECT-1:0]      in_weights,
    input  logic signed [FEAT_W-1:0]   in_threshold,
    input  logic [LEAF_W-1:0]          in_leaf_left,
    input  logic [LEAF_W-1:0]          in_leaf_right,
    output logic                       s1_valid,
    output logic [NUM_RECT*RECT_W-1:0] s1_sums,
    output logic [2*NUM_RECT-1:0]      s1_weights,
    output logic signed [FEAT_W-1:0]   s1_threshold,
    output logic [LEAF_W-1:0]          s1_left,
    output logic [LEAF_W-1:0]          s1_right
);
    import hf_pkg::*;

    logic [NUM_RECT*RECT_W-1:0] sums_next;

    for (genvar k = 0; k < NUM_RECT; k++) begin : g_rect
        localparam int BASE = k * CORNERS_PER_RECT;
        logic signed [RECT_W-1:0] tl, tr, bl, br;
        always_comb begin
            tl = $signed({2'b00, in_corners[(BASE + C_TL)*CORNER_W +: CORNER_W]});
            tr = $signed({2'b00, in_corners[(BASE + C_TR)*CORNER_W +: CORNER_W]});
            bl = $signed({2'b00, in_corners[(BASE + C_BL)*CORNER_W +: CORNER_W]});
            br = $signed({2'b00, in_corners[(BASE + C_BR)*CORNER_W +: CORNER_W]});
            sums_next[k*RECT_W +: RECT_W] = br - tr - bl + tl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_sums      <= sums_next;
            s1_weights   <= in_weights;
            s1_threshold <= in_threshold;
            s1_left      <= in_leaf_left;
            s1_right     <= in_leaf_right;
        end
    end

    // R6: valid advances one register per cycle
    a_r6_valid_enters: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r6_idle_enters: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);

    // R2: a rectangle whose four corners are equal sums to zero
    a_r2_flat_rect_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid
         && in_corners[C_TL*CORNER_W +: CORNER_W] == in_corners[C_TR*CORNER_W +: CORNER_W]
         && in_corners[C_TL*CORNER_W +: CORNER_W] == in_corners[C_BL*CORNER_W +: CORNER_W]
         && in_corners[C_TL*CORNER_W +: CORNER_W] == in_corners[C_BR*CORNER_W +: CORNER_W])
        |=> (s1_sums[RECT_W-1:0] == '0));

endmodule

// File: rtl/hf_decide_stage.sv
module hf_decide_stage #(
    parameter int CORNER_W = 17,
    parameter int NUM_RECT = 3,
    parameter int LEAF_W   = 16,
    parameter int FEAT_W   = 23,
    localparam int RECT_W  = CORNER_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s1_valid,
    input  logic [NUM_RECT*RECT_W-1:0] s1_sums,
    input  logic [2*NUM_RECT-1:0]      s1_weights,
    input  logic signed [FEAT_W-1:0]   s1_threshold,
    input  logic [LEAF_W-1:0]          s1_left,
    input  logic [LEAF_W-1:0]          s1_right,
    output logic                       out_valid,
    output logic [LEAF_W-1:0]          out_leaf
);
    import hf_pkg::*;

    logic signed [FEAT_W-1:0] scaled [NUM_RECT];
    logic signed [FEAT_W-1:0] feat_value;
    logic                     go_right;

    for (genvar k = 0; k < NUM_RECT; k++) begin : g_weight
        logic [RECT_W-1:0]        raw;
        logic signed [FEAT_W-1:0] ext;
        always_comb begin
            raw = s1_sums[k*RECT_W +: RECT_W];
            ext = $signed({{(FEAT_W-RECT_W){raw[RECT_W-1]}}, raw});
            unique case (weight_e'(s1_weights[2*k +: 2]))
                W_ZERO:   scaled[k] = '0;
                W_NEG:    scaled[k] = -ext;
                W_DOUBLE: scaled[k] = ext <<< 1;
                W_TRIPLE: scaled[k] = ext + (ext <<< 1);
                default:  scaled[k] = '0;
            endcase
        end
    end

    always_comb begin
        feat_value = '0;
        for (int k = 0; k < NUM_RECT; k++) begin
            feat_value = feat_value + scaled[k];
        end
        go_right = (feat_value > s1_threshold);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_leaf  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_leaf <= go_right ? s1_right : s1_left;
            end
        end
    end

    // R6: result follows stage one by exactly one cycle
    a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);

    // R5: result is always one of the two leaves presented
    a_r5_one_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (out_leaf == $past(s1_left) || out_leaf == $past(s1_right)));

    // R7: no new result, no change
    a_r7_hold_leaf: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_leaf));

    // R8: all weights zero gives feature value zero, so the threshold sign decides
    a_r8_all_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_weights == '0) |=>
        (out_leaf == (($signed($past(s1_threshold)) < 0) ? $past(s1_right) : $past(s1_left))));

endmodule

// File: rtl/hf_feature_eval.sv
module hf_feature_eval #(
    parameter int CORNER_W = 17,
    parameter int NUM_RECT = 3,
    parameter int LEAF_W   = 16,
    localparam int FEAT_W  = CORNER_W + 4 + $clog2(NUM_RECT + 1),
    localparam int RECT_W  = CORNER_W + 2,
    localparam int IN_W    = NUM_RECT * hf_pkg::CORNERS_PER_RECT * CORNER_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_corners,
    input  logic [2*NUM_RECT-1:0]    in_weights,
    input  logic signed [FEAT_W-1:0] in_threshold,
    input  logic [LEAF_W-1:0]        in_leaf_left,
    input  logic [LEAF_W-1:0]        in_leaf_right,
    output logic                     out_valid,
    output logic [LEAF_W-1:0]        out_leaf
);
    logic                       s1_valid;
    logic [NUM_RECT*RECT_W-1:0] s1_sums;
    logic [2*NUM_RECT-1:0]      s1_weights;
    logic signed [FEAT_W-1:0]   s1_threshold;
    logic [LEAF_W-1:0]          s1_left;
    logic [LEAF_W-1:0]          s1_right;

    hf_rect_stage #(
        .CORNER_W(CORNER_W), .NUM_RECT(NUM_RECT), .LEAF_W(LEAF_W), .FEAT_W(FEAT_W)
    ) u_rect (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_corners   (in_corners),
        .in_weights   (in_weights),
        .in_threshold (in_threshold),
        .in_leaf_left (in_leaf_left),
        .in_leaf_right(in_leaf_right),
        .s1_valid     (s1_valid),
        .s1_sums      (s1_sums),
        .s1_weights   (s1_weights),
        .s1_threshold (s1_threshold),
        .s1_left      (s1_left),
        .s1_right     (s1_right)
    );

    hf_decide_stage #(
        .CORNER_W(CORNER_W), .NUM_RECT(NUM_RECT), .LEAF_W(LEAF_W), .FEAT_W(FEAT_W)
    ) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_sums     (s1_sums),
        .s1_weights  (s1_weights),
        .s1_threshold(s1_threshold),
        .s1_left     (s1_left),
        .s1_right    (s1_right),
        .out_valid   (out_valid),
        .out_leaf    (out_leaf)
    );

    // R1: reset clears the result register
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_leaf == '0));

endmodule

// File: tb/hf_feature_eval_bench.sv
`timescale 1ns/1ps
module hf_feature_eval_bench;
    localparam int CW = 17;
    localparam int NR = 3;
    localparam int LW = 16;
    localparam int FW = 23;
    localparam int IW = NR * 4 * CW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_corners = '0;
    logic [2*NR-1:0] in_weights = '0;
    logic [FW-1:0] in_threshold = '0;
    logic [LW-1:0] in_leaf_left = '0;
    logic [LW-1:0] in_leaf_right = '0;
    logic          out_valid;
    logic [LW-1:0] out_leaf;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit            p0_v = 0, p1_v = 0;
    logic [LW-1:0] p0_leaf = '0, p1_leaf = '0, last_leaf = '0;
    string         p0_tag = "", p1_tag = "";

    always #2.5 clk = ~clk;

    hf_feature_eval u_hf_feature_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_corners(in_corners),
        .in_weights(in_weights), .in_threshold(in_threshold),
        .in_leaf_left(in_leaf_left), .in_leaf_right(in_leaf_right),
        .out_valid(out_valid), .out_leaf(out_leaf)
    );

    function automatic int feature_total(input logic [IW-1:0] c, input logic [2*NR-1:0] w);
        int tot = 0;
        for (int k = 0; k < NR; k++) begin
            int tl = int'(c[(4*k+0)*CW +: CW]);
            int tr = int'(c[(4*k+1)*CW +: CW]);
            int bl = int'(c[(4*k+2)*CW +: CW]);
            int br = int'(c[(4*k+3)*CW +: CW]);
            int s = br - tr - bl + tl;
            case (w[2*k +: 2])
                2'b00: tot += 0;
                2'b01: tot -= s;
                2'b10: tot += 2 * s;
                default: tot += 3 * s;
            endcase
        end
        return tot;
    endfunction

    function automatic logic [IW-1:0] make_rect(input logic [IW-1:0] c, input int k,
                                                input int tl, input int tr, input int bl, input int br);
        logic [IW-1:0] r = c;
        r[(4*k+0)*CW +: CW] = tl[CW-1:0];
        r[(4*k+1)*CW +: CW] = tr[CW-1:0];
        r[(4*k+2)*CW +: CW] = bl[CW-1:0];
        r[(4*k+3)*CW +: CW] = br[CW-1:0];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [IW-1:0] c, input logic [2*NR-1:0] w,
                        input int thr, input logic [LW-1:0] l, input logic [LW-1:0] r,
                        input string tag);
        @(negedge clk);
        check(out_valid == p1_v, "R6", "out_valid", int'(out_valid), int'(p1_v));
        if (p1_v) begin
            check(out_leaf == p1_leaf, p1_tag, "out_leaf", int'(out_leaf), int'(p1_leaf));
            last_leaf = p1_leaf;
        end else begin
            check(out_leaf == last_leaf, "R7", "held out_leaf", int'(out_leaf), int'(last_leaf));
        end
        in_valid      = v;
        in_corners    = c;
        in_weights    = w;
        in_threshold  = thr[FW-1:0];
        in_leaf_left  = l;
        in_leaf_right = r;
        p1_v = p0_v; p1_leaf = p0_leaf; p1_tag = p0_tag;
        p0_v = v;
        p0_leaf = (feature_total(c, w) > thr) ? r : l;
        p0_tag = tag;
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 0, 16'h0, 16'h0, "R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] c;
        int tot;
        int seed_v;
        seed_v = $urandom(32'h5EED1234);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_leaf == '0, "R1", "out_leaf in reset", int'(out_leaf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_leaf == '0, "R1", "out_leaf after reset", int'(out_leaf), 0);

        // R2: single rectangle, known corners: 9 - 3 - 3 + 1 = 4, weight x2 -> 8
        c = make_rect('0, 0, 1, 3, 3, 9);
        step(1'b1, c, 6'b00_00_10, 7, 16'h1111, 16'h2222, "R2");
        step(1'b1, c, 6'b00_00_10, 8, 16'h1111, 16'h2222, "R2");
        // R3: each code on the second rectangle with sum 4
        c = make_rect('0, 1, 1, 3, 3, 9);
        step(1'b1, c, 6'b00_01_00, -5, 16'hA001, 16'hA002, "R3");
        step(1'b1, c, 6'b00_01_00, -4, 16'hA003, 16'hA004, "R3");
        step(1'b1, c, 6'b00_11_00, 11, 16'hA005, 16'hA006, "R3");
        step(1'b1, c, 6'b00_11_00, 12, 16'hA007, 16'hA008, "R3");
        idle(); idle();

        // R4: full-scale positive and negative totals under x3
        c = '0;
        for (int k = 0; k < NR; k++) c = make_rect(c, k, CMAX, 0, 0, CMAX);
        tot = feature_total(c, 6'b11_11_11);
        step(1'b1, c, 6'b11_11_11, tot - 1, 16'hB001, 16'hB002, "R4");
        step(1'b1, c, 6'b11_11_11, tot, 16'hB003, 16'hB004, "R4");
        c = '0;
        for (int k = 0; k < NR; k++) c = make_rect(c, k, 0, CMAX, CMAX, 0);
        tot = feature_total(c, 6'b11_11_11);
        step(1'b1, c, 6'b11_11_11, tot - 1, 16'hB005, 16'hB006, "R4");
        step(1'b1, c, 6'b11_11_11, tot, 16'hB007, 16'hB008, "R4");
        step(1'b1, c, 6'b01_01_01, -tot / 3 - 1, 16'hB009, 16'hB00A, "R4");
        idle();

        // R5: signed threshold, equality goes left
        step(1'b1, '0, 6'b00_00_00, -1, 16'hC001, 16'hC002, "R5");
        step(1'b1, '0, 6'b00_00_00, 0, 16'hC003, 16'hC004, "R5");
        step(1'b1, '0, 6'b00_00_00, -(1 << (FW-1)), 16'hC005, 16'hC006, "R5");
        step(1'b1, '0, 6'b00_00_00, (1 << (FW-1)) - 1, 16'hC007, 16'hC008, "R5");

        // R8: garbage corners on a zero-weight rectangle
        for (int i = 0; i < 6; i++) begin
            c = make_rect('0, 0, 2, 5, 7, 20);
            c = make_rect(c, 2, int'($urandom_range(0, CMAX)), int'($urandom_range(0, CMAX)),
                          int'($urandom_range(0, CMAX)), int'($urandom_range(0, CMAX)));
            step(1'b1, c, 6'b00_00_11, 30 + (i % 3) - 1, 16'hD000 + 16'(i), 16'hE000 + 16'(i), "R8");
        end
        idle(); idle(); idle();

        // Random mix with gaps and back-to-back traffic
        for (int i = 0; i < 400; i++) begin
            bit v;
            logic [2*NR-1:0] w;
            int thr;
            int mode;
            logic [LW-1:0] l, r;
            v = ($urandom_range(0, 3) != 0);
            for (int j = 0; j < NR*4; j++) c[j*CW +: CW] = CW'($urandom_range(0, CMAX));
            w = 6'($urandom_range(0, 63));
            tot = feature_total(c, w);
            mode = int'($urandom_range(0, 3));
            case (mode)
                0: thr = tot;
                1: thr = tot + 1;
                2: thr = tot - 1;
                default: thr = int'($urandom_range(0, (1 << FW) - 1)) - (1 << (FW-1));
            endcase
            l = LW'($urandom_range(0, 65535));
            r = l ^ 16'h5A5A;
            step(v, c, w, thr, l, r, (mode == 3) ? "R4" : "R5");
        end
        idle(); idle(); idle();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule